// File: doc/BRIEF.md
# Dual-Lane Pipelined Multiply Issue Engine

This block buffers register-to-register multiply operations in a small in-order queue and sends them to two identical multiply lanes. Each lane is pipelined, so it takes a new operation every cycle while older ones are still in flight. A one-bit-per-register scoreboard holds back an operation only when it truly depends on a result that is not yet written. This covers a source still being computed and a destination still owned by an older in-flight operation.

Each operation names a destination register, two source registers and a tag. The result is the low word of the product of the two source values. When an operation completes, the engine writes the result into its internal register file and reports the tag, destination and value on one of two completion slots. A surrounding core feeds the queue at up to two operations per cycle. It uses the completion slots to retire tags.

Top module: `mulx_dual_issue`

## Requirements
- R1: Two lanes each accept one new multiply per cycle. A continuous stream of mutually independent operations pushed two per cycle produces two completions in every cycle, that is 0.5 cycles per operation.
- R2: An operation pushed at a rising edge into an empty, idle engine issues in the following cycle. Its completion is visible three cycles after issue. Operations issued in cycle c complete in cycle c+3 whatever else is in flight.
- R3: An operation whose source register is written by an older in-flight operation issues in the cycle in which that producer completes, and not earlier. A chain of four dependent multiplies completes at cycles 3, 6, 9 and 12 after the first one issues.
- R4: An operation whose destination is still owned by an older in-flight operation waits until that owner completes. Two completions in the same cycle never name the same destination.
- R5: Operations issue strictly in queue order. A younger operation never issues before an older one, even when the younger one has no hazard.
- R6: The second operation of an issue pair issues only if the first issues in the same cycle. It also must neither read nor write the first one's destination. Otherwise it waits for a later cycle.
- R7: The result is the low 32 bits of the product of the two source values. The source values are those left by all older operations in program order, including a result forwarded in its own completion cycle.
- R8: After reset, register i holds 3*i+1.
- R9: in_ready is high exactly when at least two queue slots are free. Slot 0 of a push is older than slot 1. A push offered while in_ready is low is discarded and never executes.
- R10: Reset clears the queue, both lane pipelines and the scoreboard. After reset done_valid is 0, in_ready is 1, and no operation queued or in flight before reset ever completes.
- R11: When two operations complete in the same cycle, the older one is on completion slot 0. Slot 1 is never valid without slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Push request per slot, slot 0 older |
| in_dst | input | 2x4 | Destination register index per slot |
| in_src_a | input | 2x4 | First source register index per slot |
| in_src_b | input | 2x4 | Second source register index per slot |
| in_tag | input | 2x6 | Operation tag per slot |
| in_ready | output | 1 | At least two queue slots are free |
| done_valid | output | 2 | Completion per slot, slot 0 older |
| done_dst | output | 2x4 | Destination register written |
| done_tag | output | 2x6 | Tag of the completing operation |
| done_data | output | 2x32 | Result value written back |

## Verification
The hardest case to reach is a write-back landing in the same cycle that a blocked operation becomes eligible. The waiter must read the forwarded value while its own write-after-write claim replaces the bit being cleared. The stimulus reaches it by pushing a same-destination pair, then a reader of that destination one cycle later. The reader's completion cycle and value then show whether the bypass and scoreboard hand-over line up. A second hard case is a full queue. A chain of self-dependent pairs drains one operation every three cycles, which holds the queue at seven entries. A push offered in that window must leave no trace, and the bench checks this by reading the targeted register afterwards.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

   // number of issue slots and multiply lanes
   localparam int unsigned LANES = 2;

   // how a lane spreads the multiplication over its stages
   typedef enum logic {
      MUL_FLAT  = 1'b0,
      MUL_SPLIT = 1'b1
   } mul_style_e;

endpackage

// File: rtl/mulx_op_queue.sv
module mulx_op_queue
   import mulx_pkg::*;
#(
   parameter int unsigned WIDTH = 18,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [LANES-1:0]            push_v,
   input  logic [LANES-1:0][WIDTH-1:0] push_word,
   input  logic [1:0]                  pop_cnt,
   output logic [LANES-1:0][WIDTH-1:0] head_word,
   output logic [CNT_W-1:0]            count,
   output logic                        room2
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W-1:0] wr_ptr;
   logic [CNT_W-1:0] n_push;
   logic [PTR_W-1:0] wr_ptr_b;

   assign n_push   = CNT_W'(push_v[0]) + CNT_W'(push_v[1]);
   assign wr_ptr_b = wr_ptr + PTR_W'(push_v[0]);

   // slot 1 lands after slot 0 when both push, at the tail when alone
   always_ff @(posedge clk) begin
      if (push_v[0]) mem[wr_ptr]   <= push_word[0];
      if (push_v[1]) mem[wr_ptr_b] <= push_word[1];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         rd_ptr <= rd_ptr + PTR_W'(pop_cnt);
         wr_ptr <= wr_ptr + PTR_W'(n_push);
         count  <= count + n_push - CNT_W'(pop_cnt);
      end
   end

   assign head_word[0] = mem[rd_ptr];
   assign head_word[1] = mem[rd_ptr + PTR_W'(1)];
   assign room2        = (count <= CNT_W'(DEPTH - 2));

endmodule

// File: rtl/mulx_scoreboard.sv
module mulx_scoreboard
   import mulx_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned RIDX_W = $clog2(NUM_REGS)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [LANES-1:0]             set_v,
   input  logic [LANES-1:0][RIDX_W-1:0] set_idx,
   input  logic [LANES-1:0]             clr_v,
   input  logic [LANES-1:0][RIDX_W-1:0] clr_idx,
   output logic [NUM_REGS-1:0]          busy,
   output logic [NUM_REGS-1:0]          busy_eff
);

   logic [NUM_REGS-1:0] set_mask;
   logic [NUM_REGS-1:0] clr_mask;

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      for (int l = 0; l < int'(LANES); l++) begin
         if (set_v[l]) set_mask[set_idx[l]] = 1'b1;
         if (clr_v[l]) clr_mask[clr_idx[l]] = 1'b1;
      end
   end

   // a claim made in the cycle of a release wins over the release
   always_ff @(posedge clk) begin
      if (rst) busy <= '0;
      else     busy <= (busy & ~clr_mask) | set_mask;
   end

   // registers released this cycle are already readable through the bypass
   assign busy_eff = busy & ~clr_mask;

endmodule

// File: rtl/mulx_mul_lane.sv
module mulx_mul_lane
   import mulx_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned RIDX_W = 4,
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned STAGES = 3,
   parameter mul_style_e  STYLE  = MUL_SPLIT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_v,
   input  logic [XLEN-1:0]   in_a,
   input  logic [XLEN-1:0]   in_b,
   input  logic [RIDX_W-1:0] in_dst,
   input  logic [TAG_W-1:0]  in_tag,
   output logic              out_v,
   output logic [RIDX_W-1:0] out_dst,
   output logic [TAG_W-1:0]  out_tag,
   output logic [XLEN-1:0]   out_data
);

   logic [STAGES-1:0]             v_q;
   logic [STAGES-1:0][RIDX_W-1:0] dst_q;
   logic [STAGES-1:0][TAG_W-1:0]  tag_q;

   always_ff @(posedge clk) begin
      if (rst) v_q <= '0;
      else     v_q <= {v_q[STAGES-2:0], in_v};
   end

   always_ff @(posedge clk) begin
      dst_q[0] <= in_dst;
      tag_q[0] <= in_tag;
      for (int s = 1; s < int'(STAGES); s++) begin
         dst_q[s] <= dst_q[s-1];
         tag_q[s] <= tag_q[s-1];
      end
   end

   assign out_v   = v_q[STAGES-1];
   assign out_dst = dst_q[STAGES-1];
   assign out_tag = tag_q[STAGES-1];

   if (STYLE == MUL_FLAT) begin : g_flat
      // whole product in the first stage, later stages only carry it
      logic [STAGES-1:0][XLEN-1:0] d_q;
      always_ff @(posedge clk) begin
         d_q[0] <= in_a * in_b;
         for (int s = 1; s < int'(STAGES); s++) d_q[s] <= d_q[s-1];
      end
      assign out_data = d_q[STAGES-1];
   end else begin : g_split
      // half-width partial products first, recombined in the second stage
      localparam int unsigned H = XLEN / 2;
      logic [XLEN-1:0]               lo_q;
      logic [H-1:0]                  x_q;
      logic [STAGES-1:1][XLEN-1:0]   d_q;
      always_ff @(posedge clk) begin
         lo_q   <= {{H{1'b0}}, in_a[H-1:0]} * {{H{1'b0}}, in_b[H-1:0]};
         x_q    <= in_a[H-1:0] * in_b[XLEN-1:H] + in_a[XLEN-1:H] * in_b[H-1:0];
         d_q[1] <= lo_q + {x_q, {H{1'b0}}};
         for (int s = 2; s < int'(STAGES); s++) d_q[s] <= d_q[s-1];
      end
      assign out_data = d_q[STAGES-1];
   end

endmodule

// File: rtl/mulx_dual_issue.sv
module mulx_dual_issue
   import mulx_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned NUM_REGS     = 16,
   parameter int unsigned TAG_W        = 6,
   parameter int unsigned QUEUE_DEPTH  = 8,
   parameter int unsigned MUL_STAGES   = 3,
   parameter mul_style_e  MUL_STYLE    = MUL_SPLIT,
   parameter int unsigned RF_INIT_STEP = 3,
   localparam int unsigned RIDX_W = $clog2(NUM_REGS)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [LANES-1:0]             in_valid,
   input  logic [LANES-1:0][RIDX_W-1:0] in_dst,
   input  logic [LANES-1:0][RIDX_W-1:0] in_src_a,
   input  logic [LANES-1:0][RIDX_W-1:0] in_src_b,
   input  logic [LANES-1:0][TAG_W-1:0]  in_tag,
   output logic                         in_ready,
   output logic [LANES-1:0]             done_valid,
   output logic [LANES-1:0][RIDX_W-1:0] done_dst,
   output logic [LANES-1:0][TAG_W-1:0]  done_tag,
   output logic [LANES-1:0][XLEN-1:0]   done_data
);

   localparam int unsigned CNT_W = $clog2(QUEUE_DEPTH + 1);

   typedef struct packed {
      logic [RIDX_W-1:0] dst;
      logic [RIDX_W-1:0] sa;
      logic [RIDX_W-1:0] sb;
      logic [TAG_W-1:0]  tag;
   } op_t;

   localparam int unsigned OP_W = $bits(op_t);

   // elaboration-time parameter checks
   if (QUEUE_DEPTH < 4 || (QUEUE_DEPTH & (QUEUE_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("QUEUE_DEPTH must be a power of two, at least 4");
   end
   if (NUM_REGS < 2 || (1 << RIDX_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (MUL_STAGES < 2) begin : g_bad_stages
      $error("MUL_STAGES must be at least 2");
   end
   if (MUL_STYLE == MUL_SPLIT && (XLEN % 2) != 0) begin : g_bad_split
      $error("split multiply needs an even XLEN");
   end

   logic [LANES-1:0]             push_v;
   logic [LANES-1:0][OP_W-1:0]   push_word;
   logic [LANES-1:0][OP_W-1:0]   head_word;
   logic [CNT_W-1:0]             q_count;
   logic                         q_room2;
   op_t                          hd [LANES];
   logic [LANES-1:0]             hv;
   logic [LANES-1:0]             iss;
   logic [1:0]                   pop_cnt;
   logic [NUM_REGS-1:0]          sb_busy;
   logic [NUM_REGS-1:0]          busy_eff;
   logic [LANES-1:0][RIDX_W-1:0] iss_dst;
   logic [LANES-1:0][XLEN-1:0]   opa;
   logic [LANES-1:0][XLEN-1:0]   opb;
   logic [LANES-1:0]             wb_v;
   logic [LANES-1:0][RIDX_W-1:0] wb_dst;
   logic [LANES-1:0][TAG_W-1:0]  wb_tag;
   logic [LANES-1:0][XLEN-1:0]   wb_data;
   logic [XLEN-1:0]              rf [NUM_REGS];

   // ---------------- queue ----------------
   assign in_ready = q_room2;
   assign push_v   = in_valid & {LANES{q_room2}};

   for (genvar l = 0; l < int'(LANES); l++) begin : g_slot
      assign push_word[l] = {in_dst[l], in_src_a[l], in_src_b[l], in_tag[l]};
      assign hd[l]        = head_word[l];
      assign iss_dst[l]   = hd[l].dst;
   end

   mulx_op_queue #(
      .WIDTH (OP_W),
      .DEPTH (QUEUE_DEPTH)
   ) queue_i (
      .clk       (clk),
      .rst       (rst),
      .push_v    (push_v),
      .push_word (push_word),
      .pop_cnt   (pop_cnt),
      .head_word (head_word),
      .count     (q_count),
      .room2     (q_room2)
   );

   assign hv[0] = (q_count != '0);
   assign hv[1] = (q_count >= CNT_W'(2));

   // ---------------- in-order dual issue ----------------
   always_comb begin
      iss[0] = hv[0] && !busy_eff[hd[0].sa] && !busy_eff[hd[0].sb]
               && !busy_eff[hd[0].dst];
      iss[1] = hv[1] && iss[0]
               && !busy_eff[hd[1].sa] && !busy_eff[hd[1].sb] && !busy_eff[hd[1].dst]
               && (hd[1].sa != hd[0].dst) && (hd[1].sb != hd[0].dst)
               && (hd[1].dst != hd[0].dst);
   end

   assign pop_cnt = {1'b0, iss[0]} + {1'b0, iss[1]};

   mulx_scoreboard #(
      .NUM_REGS (NUM_REGS)
   ) sb_i (
      .clk      (clk),
      .rst      (rst),
      .set_v    (iss),
      .set_idx  (iss_dst),
      .clr_v    (wb_v),
      .clr_idx  (wb_dst),
      .busy     (sb_busy),
      .busy_eff (busy_eff)
   );

   // ---------------- operand read with write-back bypass ----------------
   always_comb begin
      for (int l = 0; l < int'(LANES); l++) begin
         opa[l] = rf[hd[l].sa];
         opb[l] = rf[hd[l].sb];
         for (int w = 0; w < int'(LANES); w++) begin
            if (wb_v[w] && wb_dst[w] == hd[l].sa) opa[l] = wb_data[w];
            if (wb_v[w] && wb_dst[w] == hd[l].sb) opb[l] = wb_data[w];
         end
      end
   end

   // ---------------- lanes ----------------
   for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      mulx_mul_lane #(
         .XLEN   (XLEN),
         .RIDX_W (RIDX_W),
         .TAG_W  (TAG_W),
         .STAGES (MUL_STAGES),
         .STYLE  (MUL_STYLE)
      ) lane_i (
         .clk      (clk),
         .rst      (rst),
         .in_v     (iss[l]),
         .in_a     (opa[l]),
         .in_b     (opb[l]),
         .in_dst   (hd[l].dst),
         .in_tag   (hd[l].tag),
         .out_v    (wb_v[l]),
         .out_dst  (wb_dst[l]),
         .out_tag  (wb_tag[l]),
         .out_data (wb_data[l])
      );
   end

   // ---------------- register file, two write ports ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(NUM_REGS); i++) rf[i] <= XLEN'(i * RF_INIT_STEP + 1);
      end else begin
         for (int w = 0; w < int'(LANES); w++) begin
            if (wb_v[w]) rf[wb_dst[w]] <= wb_data[w];
         end
      end
   end

   assign done_valid = wb_v;
   assign done_dst   = wb_dst;
   assign done_tag   = wb_tag;
   assign done_data  = wb_data;

endmodule

// File: rtl/mulx_dual_issue_chk.sv
module mulx_dual_issue_chk #(
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned QUEUE_DEPTH = 8,
   parameter int unsigned MUL_STAGES  = 3,
   localparam int unsigned RIDX_W = $clog2(NUM_REGS),
   localparam int unsigned CNT_W  = $clog2(QUEUE_DEPTH + 1)
) (
   input logic                    clk,
   input logic                    rst,
   input logic [1:0]              iss,
   input logic [CNT_W-1:0]        q_count,
   input logic [NUM_REGS-1:0]     sb_busy,
   input logic [1:0]              done_valid,
   input logic [1:0][RIDX_W-1:0]  done_dst
);

   a_r11_slot1_needs_slot0: assert property (@(posedge clk) disable iff (rst)
      done_valid[1] |-> done_valid[0]);

   a_r4_distinct_wb_dst: assert property (@(posedge clk) disable iff (rst)
      (done_valid == 2'b11) |-> (done_dst[0] != done_dst[1]));

   a_r3_dst_busy_in_flight: assert property (@(posedge clk) disable iff (rst)
      done_valid[0] |-> sb_busy[done_dst[0]]);

   a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
      q_count <= CNT_W'(QUEUE_DEPTH));

   a_r10_reset_clears: assert property (@(posedge clk)
      $past(rst) |-> (done_valid == 2'b00 && sb_busy == '0 && q_count == '0));

   if (MUL_STAGES == 3) begin : g_lat3
      a_r2_latency: assert property (@(posedge clk) disable iff (rst)
         ($past(iss[0], 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
         |-> done_valid[0]);
   end

endmodule

bind mulx_dual_issue mulx_dual_issue_chk #(
   .NUM_REGS    (NUM_REGS),
   .QUEUE_DEPTH (QUEUE_DEPTH),
   .MUL_STAGES  (MUL_STAGES)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .iss        (iss),
   .q_count    (q_count),
   .sb_busy    (sb_busy),
   .done_valid (done_valid),
   .done_dst   (done_dst)
);

// File: tb/mulx_dual_issue_tb_top.sv
module mulx_dual_issue_tb_top;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [1:0]       in_valid = '0;
   logic [1:0][3:0]  in_dst = '0;
   logic [1:0][3:0]  in_src_a = '0;
   logic [1:0][3:0]  in_src_b = '0;
   logic [1:0][5:0]  in_tag = '0;
   logic             in_ready;
   logic [1:0]       done_valid;
   logic [1:0][3:0]  done_dst;
   logic [1:0][5:0]  done_tag;
   logic [1:0][31:0] done_data;

   always #2.5 clk = ~clk;   // 200 MHz

   mulx_dual_issue dut_i (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_dst     (in_dst),
      .in_src_a   (in_src_a),
      .in_src_b   (in_src_b),
      .in_tag     (in_tag),
      .in_ready   (in_ready),
      .done_valid (done_valid),
      .done_dst   (done_dst),
      .done_tag   (done_tag),
      .done_data  (done_data)
   );

   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] mrf [16];
   logic [31:0] exp_val [64];
   logic [31:0] got_val [64];
   int          got_n   [64];
   int          got_cyc [64];
   int          got_lane[64];

   always @(posedge clk) cyc <= cyc + 1;

   // completion monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         for (int l = 0; l < 2; l++) begin
            if (done_valid[l]) begin
               got_n[done_tag[l]]    <= got_n[done_tag[l]] + 1;
               got_cyc[done_tag[l]]  <= cyc;
               got_lane[done_tag[l]] <= l;
               got_val[done_tag[l]]  <= done_data[l];
            end
         end
      end
   end

   function automatic logic [31:0] mul32(input logic [31:0] a, input logic [31:0] b);
      return a * b;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model(input int d, input int a, input int b, input int t);
      exp_val[t] = mul32(mrf[a], mrf[b]);
      mrf[d]     = exp_val[t];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst      = 1'b1;
      in_valid = '0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         got_n[i] = 0; got_cyc[i] = 0; got_lane[i] = 0;
         got_val[i] = '0; exp_val[i] = '0;
      end
      for (int i = 0; i < 16; i++) mrf[i] = 32'(i * 3 + 1);
      rst = 1'b0;
   endtask

   // drive one push at the current falling edge; pc is the cycle of the capturing edge
   task automatic push2(input bit v0, input int d0, input int a0, input int b0, input int t0,
                        input bit v1, input int d1, input int a1, input int b1, input int t1,
                        output int pc);
      while (!in_ready) @(negedge clk);
      in_valid    = {v1, v0};
      in_dst[0]   = 4'(d0); in_src_a[0] = 4'(a0); in_src_b[0] = 4'(b0); in_tag[0] = 6'(t0);
      in_dst[1]   = 4'(d1); in_src_a[1] = 4'(a1); in_src_b[1] = 4'(b1); in_tag[1] = 6'(t1);
      if (v0) model(d0, a0, b0, t0);
      if (v1) model(d1, a1, b1, t1);
      pc = cyc + 1;
      @(negedge clk);
      in_valid = '0;
   endtask

   task automatic expect_done(input int t, input int ecyc, input int elane, input string req);
      chk(got_n[t] == 1, req, $sformatf("tag %0d completions", t), got_n[t], 1);
      chk(got_cyc[t] == ecyc, req, $sformatf("tag %0d cycle", t), got_cyc[t], ecyc);
      chk(got_lane[t] == elane, req, $sformatf("tag %0d slot", t), got_lane[t], elane);
      chk(got_val[t] == exp_val[t], "R7", $sformatf("tag %0d value", t),
          got_val[t], exp_val[t]);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk(done_valid == 2'b00, "R10", "done_valid after reset", done_valid, 0);
      chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
   endtask

   task automatic t_dep_chain();   // R3 R8
      int p, q;
      do_reset();
      push2(1, 1, 2, 3, 10, 0, 0, 0, 0, 0, p);
      push2(1, 4, 1, 1, 11, 0, 0, 0, 0, 0, q);
      push2(1, 5, 4, 4, 12, 0, 0, 0, 0, 0, q);
      push2(1, 6, 5, 5, 13, 0, 0, 0, 0, 0, q);
      repeat (16) @(negedge clk);
      expect_done(10, p + 3, 0, "R3");
      expect_done(11, p + 6, 0, "R3");
      expect_done(12, p + 9, 0, "R3");
      expect_done(13, p + 12, 0, "R3");
      chk(got_val[10] == 32'd70, "R8", "r2*r3 from reset values", got_val[10], 70);
   endtask

   task automatic t_indep_four();   // R1 R2 R11
      int p, q;
      do_reset();
      push2(1, 7, 2, 3, 0, 1, 8, 3, 2, 1, p);
      push2(1, 9, 2, 2, 2, 1, 10, 3, 3, 3, q);
      repeat (8) @(negedge clk);
      expect_done(0, p + 3, 0, "R2");
      expect_done(1, p + 3, 1, "R11");
      expect_done(2, p + 4, 0, "R1");
      expect_done(3, p + 4, 1, "R1");
   endtask

   task automatic t_stream();   // R1
      int p, q;
      do_reset();
      for (int k = 0; k < 8; k++) begin
         push2(1, 2 + (2 * k) % 14, 0, 1, 2 * k,
               1, 2 + (2 * k + 1) % 14, 1, 1, 2 * k + 1, q);
         if (k == 0) p = q;
      end
      repeat (10) @(negedge clk);
      for (int k = 0; k < 16; k++) expect_done(k, p + 3 + k / 2, k % 2, "R1");
   endtask

   task automatic t_in_order();   // R5 R6
      int p, q;
      do_reset();
      push2(1, 1, 2, 3, 1, 1, 4, 1, 2, 2, p);
      push2(1, 5, 2, 3, 3, 0, 0, 0, 0, 0, q);
      repeat (10) @(negedge clk);
      expect_done(1, p + 3, 0, "R6");
      expect_done(2, p + 6, 0, "R6");
      expect_done(3, p + 6, 1, "R5");
   endtask

   task automatic t_waw_bypass();   // R4 R7
      int p, q;
      do_reset();
      push2(1, 7, 2, 3, 4, 1, 7, 3, 3, 5, p);
      push2(1, 8, 7, 2, 6, 0, 0, 0, 0, 0, q);
      repeat (12) @(negedge clk);
      expect_done(4, p + 3, 0, "R4");
      expect_done(5, p + 6, 0, "R4");
      expect_done(6, p + 9, 0, "R7");
   endtask

   task automatic t_full_discard();   // R9
      int p, q;
      do_reset();
      for (int k = 0; k < 4; k++) begin
         push2(1, 1, 1, 2, 20 + 2 * k, 1, 1, 1, 2, 21 + 2 * k, q);
         if (k == 0) p = q;
      end
      chk(in_ready == 1'b0, "R9", "in_ready with seven queued", in_ready, 0);
      in_valid    = 2'b01;
      in_dst[0]   = 4'd9; in_src_a[0] = 4'd2; in_src_b[0] = 4'd2; in_tag[0] = 6'd60;
      @(negedge clk);
      in_valid = '0;
      repeat (30) @(negedge clk);
      for (int k = 0; k < 8; k++) expect_done(20 + k, p + 3 + 3 * k, 0, "R9");
      chk(got_n[60] == 0, "R9", "discarded push completions", got_n[60], 0);
      chk(in_ready == 1'b1, "R9", "in_ready after drain", in_ready, 1);
      push2(1, 10, 9, 0, 61, 0, 0, 0, 0, 0, q);
      repeat (6) @(negedge clk);
      expect_done(61, q + 3, 0, "R9");
      chk(got_val[61] == 32'd28, "R9", "r9 untouched by discarded push", got_val[61], 28);
   endtask

   task automatic t_reset_flight();   // R10
      int p, q;
      do_reset();
      push2(1, 1, 1, 2, 30, 1, 1, 1, 2, 31, p);
      push2(1, 3, 1, 2, 32, 0, 0, 0, 0, 0, q);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (20) @(negedge clk);
      chk(got_n[30] + got_n[31] + got_n[32] == 0, "R10", "completions of flushed ops",
          got_n[30] + got_n[31] + got_n[32], 0);
      chk(in_ready == 1'b1, "R10", "in_ready after mid-flight reset", in_ready, 1);
      for (int i = 0; i < 16; i++) mrf[i] = 32'(i * 3 + 1);
      push2(1, 5, 1, 2, 33, 0, 0, 0, 0, 0, q);
      repeat (6) @(negedge clk);
      expect_done(33, q + 3, 0, "R10");
      chk(got_val[33] == 32'd28, "R8", "r1*r2 after mid-flight reset", got_val[33], 28);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset_state();
      t_dep_chain();
      t_indep_four();
      t_stream();
      t_in_order();
      t_waw_bypass();
      t_full_discard();
      t_reset_flight();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule